// File: doc/BRIEF.md
# Trimmed One-Second Prescaler

This block turns a crystal-rate clock enable of roughly 32 kHz into a one-second tick for a real-time clock. It also produces a half-second phase signal for pulse-style interrupts, and a copy of the oscillator enable that trimming never touches. The count for one second is set by a crystal-select input, which picks one of two nominal rates.

Three seconds in each minute can be lengthened or shortened by an even number of oscillator cycles. These are the seconds whose BCD value is 00, 20 or 40. The amount comes from a 7-bit correction code, which cancels a known crystal frequency error in steps of about 3 ppm. The calendar outside the block supplies the BCD seconds value.

The block captures the crystal-select and code inputs once per second, at the wrap of the counter. A synchronous clear restarts the second, for use by a seconds-adjust function. A halt-reset input models an oscillator-stop event: it wipes the captured configuration and holds the divider at zero.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: With no correction active, a second lasts NOM_A enabled cycles when the captured crystal-select is 0, and NOM_B when it is 1 (defaults 32768 and 32000).
- R2: Correction applies only while `sec_bcd` is 7'h00, 7'h20 or 7'h40. Every other second uses the nominal count.
- R3: With code bit 6 = 0 and correction active, the count is nominal + (code[5:0] − 1) × STEP, with STEP = 2.
- R4: With code bit 6 = 1 and correction active, the count is nominal − ((~code[5:0]) + 1) × STEP.
- R5: Codes whose bits 5..1 are all zero (7'b0000000, 7'b0000001, 7'b1000000, 7'b1000001) give the nominal count in every second.
- R6: `half_phase` is low from the wrap of a second, and rises after floor(count/2) enabled cycles of that second, where count is the length in use for that second.
- R7: Only cycles with `osc_en` high advance the divider. `sec_tick` is a one-cycle pulse in the cycle after the enabled cycle that completes a second.
- R8: Crystal-select and code are captured when a second wraps. A change made during a second has no effect on that second, and applies to the next one.
- R9: `presc_clr` clears the sub-second count and `half_phase` on the next edge. The following tick comes after exactly one full count of enabled cycles.
- R10: `halt_rst` resets the captured crystal-select and code to 0 and holds the count at zero. The second after release is NOM_A cycles long; the next wrap captures the inputs again.
- R11: `osc_out` equals `osc_en` delayed by one clock, independent of trim, clear and halt.
- R12: While `rst_n` is low, `sec_tick`, `half_phase` and `osc_out` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Crystal-rate clock enable |
| xtal_sel | input | 1 | Crystal select: 0 picks NOM_A, 1 picks NOM_B |
| trim_code | input | 7 | Correction code, bit 6 is the direction |
| sec_bcd | input | 7 | Current seconds value in BCD |
| presc_clr | input | 1 | Synchronous clear of the sub-second count |
| halt_rst | input | 1 | Oscillator-halt reset of configuration and count |
| sec_tick | output | 1 | One-cycle pulse per elapsed second |
| half_phase | output | 1 | High during the second half of each second |
| osc_out | output | 1 | Untrimmed registered copy of osc_en |

## Verification
The bench builds the block with NOM_A = 200 and NOM_B = 160, keeping STEP = 2. A full correction of ±124 cycles then stays a large fraction of a short second. Every code class can be exercised in a few thousand cycles: extreme positive, extreme negative, mid-range, smallest step, and the four codes that switch correction off. The 160-cycle nominal keeps the shortest corrected second positive, so wrap, midpoint and tick timing are measured exactly for both crystal choices. The enable runs two cycles in three, so the tests also show that idle clock cycles never count.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

  // Width of the correction code; bit CODE_W-1 selects the direction.
  localparam int CODE_W = 7;
  // BCD seconds: 3-bit tens digit and 4-bit units digit.
  localparam int SEC_BCD_W = 7;

  typedef struct packed {
    logic              xsel;
    logic [CODE_W-1:0] code;
  } trim_cfg_t;

  // The seconds in each minute that carry a correction.
  function automatic logic is_trim_second(input logic [SEC_BCD_W-1:0] s);
    return (s == 7'h00) || (s == 7'h20) || (s == 7'h40);
  endfunction

endpackage

// File: rtl/rtc_trim_len.sv
module rtc_trim_len
  import rtc_trim_pkg::*;
#(
  parameter int NOM_A = 32768,
  parameter int NOM_B = 32000,
  parameter int STEP  = 2,
  parameter int CNT_W = 16
) (
  input  trim_cfg_t              cfg,
  input  logic [SEC_BCD_W-1:0]   sec_bcd,
  output logic [CNT_W-1:0]       len,
  output logic [CNT_W-1:0]       mid
);

  localparam int MAG_W = CODE_W - 1;
  localparam int PAD_W = CNT_W - MAG_W;
  localparam logic [CNT_W-1:0] NOM_A_V = CNT_W'(NOM_A);
  localparam logic [CNT_W-1:0] NOM_B_V = CNT_W'(NOM_B);
  localparam logic [CNT_W-1:0] STEP_V  = CNT_W'(STEP);
  localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

  logic [MAG_W-1:0] mag;
  logic [CNT_W-1:0] mag_x;
  logic [CNT_W-1:0] mag_inv_x;
  logic [CNT_W-1:0] nom;
  logic [CNT_W-1:0] slow_amt;
  logic [CNT_W-1:0] fast_amt;
  logic             corr_on;

  always_comb begin
    mag       = cfg.code[MAG_W-1:0];
    mag_x     = {{PAD_W{1'b0}}, mag};
    mag_inv_x = {{PAD_W{1'b0}}, ~mag};
    nom       = cfg.xsel ? NOM_B_V : NOM_A_V;
    slow_amt  = (mag_x - ONE_V) * STEP_V;
    fast_amt  = (mag_inv_x + ONE_V) * STEP_V;
    // Codes with a zero magnitude above bit 0 switch correction off.
    corr_on   = is_trim_second(sec_bcd) && (mag[MAG_W-1:1] != '0);
    if (!corr_on) begin
      len = nom;
    end else if (cfg.code[CODE_W-1]) begin
      len = nom - fast_amt;
    end else begin
      len = nom + slow_amt;
    end
    mid = len >> 1;
  end

endmodule

// File: rtl/rtc_cfg_shadow.sv
module rtc_cfg_shadow
  import rtc_trim_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      halt,
  input  logic      capture,
  input  trim_cfg_t cfg_in,
  output trim_cfg_t cfg_q
);

  trim_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (halt) begin
      cfg_d = '0;
    end else if (capture) begin
      cfg_d = cfg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  AST_HALT_CLEARS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (cfg_q == '0)); // R10

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !capture) |=> $stable(cfg_q)); // R8

endmodule

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [CNT_W-1:0] len,
  input  logic [CNT_W-1:0] mid,
  output logic             wrap,
  output logic             tick,
  output logic             half
);

  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             half_d;

  always_comb begin
    // The >= compare also ends a second whose length shrank below the count.
    wrap   = en && !clr && (cnt_q >= (len - ONE_V));
    cnt_d  = cnt_q;
    half_d = half;
    if (clr) begin
      cnt_d  = '0;
      half_d = 1'b0;
    end else if (en) begin
      cnt_d  = wrap ? '0 : (cnt_q + ONE_V);
      half_d = (cnt_d >= mid);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      half  <= 1'b0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      half  <= half_d;
      tick  <= wrap;
    end
  end

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !half); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt_q) && $stable(half)); // R7

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R7

  AST_TICK_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> tick && (cnt_q == '0)); // R7

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int NOM_A       = 32768,
  parameter int NOM_B       = 32000,
  parameter int STEP        = 2,
  parameter bit OSC_OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 osc_en,
  input  logic                 xtal_sel,
  input  logic [CODE_W-1:0]    trim_code,
  input  logic [SEC_BCD_W-1:0] sec_bcd,
  input  logic                 presc_clr,
  input  logic                 halt_rst,
  output logic                 sec_tick,
  output logic                 half_phase,
  output logic                 osc_out
);

  localparam int NOM_MAX = (NOM_A > NOM_B) ? NOM_A : NOM_B;
  localparam int NOM_MIN = (NOM_A > NOM_B) ? NOM_B : NOM_A;
  localparam int MAX_ADJ = ((2 ** (CODE_W - 1)) - 2) * STEP;
  localparam int CNT_W   = $clog2(NOM_MAX + MAX_ADJ + 1);
  localparam logic [CNT_W-1:0] LEN_HI = CNT_W'(NOM_MAX + MAX_ADJ);
  localparam logic [CNT_W-1:0] LEN_LO = CNT_W'(NOM_MIN - MAX_ADJ);

  trim_cfg_t        cfg_in;
  trim_cfg_t        cfg_q;
  logic [CNT_W-1:0] sec_len;
  logic [CNT_W-1:0] sec_mid;
  logic             div_clr;
  logic             div_wrap;

  assign cfg_in  = '{xsel: xtal_sel, code: trim_code};
  assign div_clr = presc_clr | halt_rst;

  rtc_cfg_shadow u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .halt    (halt_rst),
    .capture (div_wrap),
    .cfg_in  (cfg_in),
    .cfg_q   (cfg_q)
  );

  rtc_trim_len #(
    .NOM_A (NOM_A),
    .NOM_B (NOM_B),
    .STEP  (STEP),
    .CNT_W (CNT_W)
  ) u_len (
    .cfg     (cfg_q),
    .sec_bcd (sec_bcd),
    .len     (sec_len),
    .mid     (sec_mid)
  );

  rtc_sec_divider #(
    .CNT_W (CNT_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (osc_en),
    .clr   (div_clr),
    .len   (sec_len),
    .mid   (sec_mid),
    .wrap  (div_wrap),
    .tick  (sec_tick),
    .half  (half_phase)
  );

  generate
    if (OSC_OUT_REG) begin : g_osc_reg
      logic osc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          osc_q <= 1'b0;
        end else begin
          osc_q <= osc_en;
        end
      end
      assign osc_out = osc_q;

      AST_OSC_PASS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en |=> osc_out); // R11
      AST_OSC_PASS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> !osc_out); // R11
    end else begin : g_osc_comb
      assign osc_out = osc_en & rst_n;
    end
  endgenerate

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_len <= LEN_HI) && (sec_len >= LEN_LO)); // R3

  AST_OFF_SECOND_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    !is_trim_second(sec_bcd) |->
      (sec_len == (cfg_q.xsel ? CNT_W'(NOM_B) : CNT_W'(NOM_A)))); // R2

endmodule

// File: tb/sim_rtc_trim_prescaler.sv
`timescale 1ns/1ps
module sim_rtc_trim_prescaler;

  localparam int NA = 200;
  localparam int NB = 160;
  localparam int NV = 14;

  // {req[31:28], xsel[27], code[26:20], sec[19:12], expected count[11:0]}
  localparam logic [31:0] VEC [NV] = '{
    {4'd5, 1'b0, 7'b0000000, 8'h00, 12'd200},  // R5 zero code
    {4'd5, 1'b0, 7'b0000001, 8'h20, 12'd200},  // R5 plus-one code
    {4'd3, 1'b0, 7'b0101001, 8'h00, 12'd280},  // R3 mid slow
    {4'd2, 1'b0, 7'b0101001, 8'h01, 12'd200},  // R2 off second
    {4'd3, 1'b0, 7'b0111111, 8'h40, 12'd324},  // R3 max slow
    {4'd4, 1'b0, 7'b1000010, 8'h20, 12'd76},   // R4 max fast
    {4'd4, 1'b0, 7'b1101001, 8'h40, 12'd154},  // R4 mid fast
    {4'd5, 1'b0, 7'b1000000, 8'h00, 12'd200},  // R5 minus-64 code
    {4'd5, 1'b0, 7'b1000001, 8'h40, 12'd200},  // R5 minus-63 code
    {4'd1, 1'b1, 7'b0000010, 8'h00, 12'd162},  // R1 R3 second crystal
    {4'd1, 1'b1, 7'b0000000, 8'h39, 12'd160},  // R1 nominal B
    {4'd4, 1'b1, 7'b1111111, 8'h20, 12'd158},  // R4 smallest fast step
    {4'd2, 1'b0, 7'b0000011, 8'h21, 12'd200},  // R2 second 21
    {4'd2, 1'b1, 7'b0111111, 8'h10, 12'd160}   // R2 second 10
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       osc_stop = 1'b0;
  logic       xtal_sel = 1'b0;
  logic [6:0] trim_code = 7'd0;
  logic [6:0] sec_bcd = 7'h05;
  logic       presc_clr = 1'b0;
  logic       halt_rst = 1'b0;
  logic       sec_tick;
  logic       half_phase;
  logic       osc_out;

  int total = 0;
  int bad = 0;
  int otot = 0;
  int obad = 0;
  int tot = 0;
  int last_tot = 0;
  int ph = 0;
  logic hprev = 1'b0;

  rtc_trim_prescaler #(.NOM_A(NA), .NOM_B(NB), .STEP(2)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_en     (osc_en),
    .xtal_sel   (xtal_sel),
    .trim_code  (trim_code),
    .sec_bcd    (sec_bcd),
    .presc_clr  (presc_clr),
    .halt_rst   (halt_rst),
    .sec_tick   (sec_tick),
    .half_phase (half_phase),
    .osc_out    (osc_out)
  );

  always #5 clk = ~clk;

  // Enable two cycles out of three.
  always @(negedge clk) begin
    ph = (ph == 2) ? 0 : ph + 1;
    osc_en = !osc_stop && (ph != 0);
  end

  // Count enables and check the pass-through output.
  always @(posedge clk) begin
    logic e;
    e = osc_en;
    if (osc_en) tot = tot + 1;
    #1;
    if (rst_n) begin
      otot = otot + 1;
      if (osc_out !== e) begin
        obad = obad + 1;
        $display("FAIL R11 osc_out act=%0b exp=%0b", osc_out, e);
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic wait_tick(output int per, output int hm);
    hm = 0;
    do begin
      @(negedge clk);
      if (half_phase && !hprev) hm = tot - last_tot;
      hprev = half_phase;
    end while (!sec_tick);
    per = tot - last_tot;
    last_tot = tot;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total + otot, bad + obad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad = bad + 1;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int p;
    int h;
    int nt;
    logic [31:0] v;
    repeat (4) @(negedge clk);
    // R12 outputs low under reset
    chk(sec_tick == 1'b0, "R12 tick in reset", int'(sec_tick), 0);
    chk(half_phase == 1'b0, "R12 half in reset", int'(half_phase), 0);
    chk(osc_out == 1'b0, "R12 osc_out in reset", int'(osc_out), 0);
    rst_n = 1'b1;
    last_tot = tot;

    // R1 first second after reset uses nominal A
    wait_tick(p, h);
    chk(p == NA, "R1 first second", p, NA);
    chk(h == NA / 2, "R6 first midpoint", h, NA / 2);
    @(negedge clk);
    chk(sec_tick == 1'b0, "R7 tick one cycle", int'(sec_tick), 0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      xtal_sel  = v[27];
      trim_code = v[26:20];
      wait_tick(p, h);
      sec_bcd = v[18:12];
      wait_tick(p, h);
      chk(p == int'(v[11:0]), $sformatf("R%0d count vector %0d", v[31:28], i), p, int'(v[11:0]));
      chk(h == int'(v[11:0]) / 2, $sformatf("R6 midpoint vector %0d", i), h, int'(v[11:0]) / 2);
    end

    // R7 idle oscillator does not advance
    xtal_sel = 1'b0; trim_code = 7'd0; sec_bcd = 7'h05;
    wait_tick(p, h);
    wait_tick(p, h);
    osc_stop = 1'b1;
    nt = 0;
    repeat (400) begin
      @(negedge clk);
      if (sec_tick) nt = nt + 1;
    end
    chk(nt == 0, "R7 no tick while idle", nt, 0);
    osc_stop = 1'b0;
    wait_tick(p, h);
    chk(p == NA, "R7 count resumes", p, NA);

    // R9 synchronous clear
    repeat (250) @(negedge clk);
    chk(half_phase == 1'b1, "R6 half high late", int'(half_phase), 1);
    presc_clr = 1'b1;
    @(negedge clk);
    presc_clr = 1'b0;
    chk(half_phase == 1'b0, "R9 half cleared", int'(half_phase), 0);
    last_tot = tot;
    hprev = 1'b0;
    wait_tick(p, h);
    chk(p == NA, "R9 full second after clear", p, NA);
    chk(h == NA / 2, "R9 midpoint after clear", h, NA / 2);

    // R8 change during a second applies from the next one
    sec_bcd = 7'h00; trim_code = 7'b0111111;
    wait_tick(p, h);
    chk(p == NA, "R8 old config this second", p, NA);
    xtal_sel = 1'b1;
    wait_tick(p, h);
    chk(p == NA + 124, "R8 new config next second", p, NA + 124);

    // R10 halt wipes the captured configuration (now crystal B, max slow)
    repeat (30) @(negedge clk);
    halt_rst = 1'b1;
    repeat (3) @(negedge clk);
    halt_rst = 1'b0;
    chk(half_phase == 1'b0, "R10 half low after halt", int'(half_phase), 0);
    last_tot = tot;
    hprev = 1'b0;
    wait_tick(p, h);
    chk(p == NA, "R10 nominal A after halt", p, NA);
    wait_tick(p, h);
    chk(p == NB + 124, "R10 recapture after halt", p, NB + 124);

    finish_run();
  end

endmodule